// File: doc/BRIEF.md
# Programmable external bus bridge

This block connects a single-word internal request port to an external system bus. The internal master presents a word address, write data, active-high byte enables and a read/write flag, and holds them with `reqValid` until the bridge answers with a one-cycle `respReady` pulse. That pulse carries the gathered read data and an error flag. On the external side the bridge drives six active-low chip selects, read and write strobes, active-low byte enables and the address and data lines. It then waits for an active-low acknowledge before it ends each strobe.

Where an access goes is set by the address alone. Three 64 MB windows fix the device width at 32, 16 or 8 bits. Inside a window, address bits [25:24] pick a chip select through a small per-select match table. A 32-bit access to a narrower device is split into several external cycles. Writes send their bytes out in turn, and reads collect the returned pieces into one word before `respReady` is raised. The bus works in one of two modes. In multiplexed mode the address and data share a 32-bit bus, and an address latch enable marks the address phase. In demultiplexed mode a separate 24-bit address is used with 16-bit data, so no external latch is needed.

Top module: `xbusBridge`

## Requirements
- R1: Byte address bits [31:26] equal to 000100, 000101 or 000110 select a 32-bit, 16-bit or 8-bit device. Any other value is outside every window.
- R2: Chip select i is hit when `cfgCsEnable[i]` is 1 and `cfgCsMatch[4i+3:4i]` equals {address[27:26], address[25:24]}. The lowest hit index wins. A miss returns `respError`=1 one cycle after `reqValid`, and no strobe is driven.
- R3: At most one `csN` bit is low at any time, and it stays low and stable from the address phase through hold. All bits are high in reset, in idle and in the response cycle.
- R4: In multiplexed mode, each external cycle begins with an address phase of `cfgSetup`+1 cycles. During this phase `ale` is 1 and `adOut` carries the external byte address. Data follows on `adOut`, and `ale` is never 1 while a strobe is low.
- R5: In demultiplexed mode, `ale` stays 0 and `addrOut` carries external address bits [23:0]. Data uses `adOut[15:0]` / `adIn[15:0]`, and an access to the 32-bit window is split into halfwords as for a 16-bit device.
- R6: With the acknowledge already low, each external cycle takes `cfgSetup`+1 address cycles, `cfgStrobe`+1 strobe cycles and `cfgHold` hold cycles. `respReady` rises 1 + n×(that sum) cycles after `reqValid`, where n is the number of external cycles.
- R7: A strobe lasts at least `cfgStrobe`+1 cycles. It ends only on a clock edge where `eackN` is sampled low.
- R8: For an 8-bit device, bytes go out in order from 0 to 3. The external address is the word address plus the byte index, the data travels on lane 0, and `beN`=1110.
- R9: For a 16-bit device, the lower halfword goes before the upper one. The external address is the word address plus 0 or 2, the data travels on lanes 1:0, and `beN[1:0]` is the inverted enables of that halfword.
- R10: An external cycle whose byte enables are all 0 is skipped. With `reqBe`=0 the bridge responds one cycle after `reqValid` with no strobe and no error.
- R11: Read data is gathered into its byte lanes. Lanes that no external cycle fetched read as 0.
- R12: A strobe that has not ended after 255 cycles ends the access with `respError`=1, and the remaining external cycles are dropped.
- R13: `respReady` is a single-cycle pulse, and `rdN` and `wrN` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present, held until `respReady` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 30 | Word address (byte address bits 31:2) |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables, active high |
| respReady | output | 1 | One-cycle completion pulse |
| respRdata | output | 32 | Gathered read data |
| respError | output | 1 | Decode miss or acknowledge timeout |
| cfgDemux | input | 1 | 1 = demultiplexed bus mode |
| cfgSetup | input | 4 | Address phase length minus one |
| cfgStrobe | input | 4 | Minimum strobe length minus one |
| cfgHold | input | 4 | Hold cycles after strobe |
| cfgCsEnable | input | 6 | Per chip select enable |
| cfgCsMatch | input | 24 | Per chip select {window, address[25:24]} |
| csN | output | 6 | Chip selects, active low |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| beN | output | 4 | Byte lane enables, active low |
| adOut | output | 32 | Address/data out |
| adOe | output | 1 | Output enable for `adOut` |
| adIn | input | 32 | Data in from the bus |
| addrOut | output | 24 | Dedicated address lines |
| eackN | input | 1 | Acknowledge, active low |

## Verification
The response is due exactly 1 + n×(setup+1 + strobe+1 + hold) edges after the request. It is one edge after the request when no external cycle runs. An acknowledge that comes late stretches only the strobe term. The bench counts the edges from the cycle it raises `reqValid` and samples one time unit after each edge, so the count of the first edge that shows `respReady` is compared with the formula exactly. A device model watches the pins on falling edges, when every bridge output is settled. It latches the address when `ale` is high, drives its acknowledge to be seen on the next rising edge, and records the chip select, byte enables and address of each strobe. This lets the bench check the address-phase length, the strobe count, the scatter order and the stored bytes independently of the response timing.

// File: rtl/xbusPkg.sv
package xbusPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_DONE
  } phaseT;

  // device width selected by address window, code equals address[27:26]
  typedef enum logic [1:0] {
    W32 = 2'd0,
    W16 = 2'd1,
    W8  = 2'd2
  } widthT;

  // strobes and phase levels from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadFirst;
    logic stepNext;
    logic capture;
    logic setErr;
    logic inAddr;
    logic inStrb;
    logic inHold;
    logic inDone;
  } ctlT;

endpackage

// File: rtl/xbusCtrl.sv
module xbusCtrl
  import xbusPkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int TIMEOUT = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             decodeHit,
  input  logic             anyActive,
  input  logic             nextValid,
  input  logic             eackN,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgStrobe,
  input  logic [CNT_W-1:0] cfgHold,
  output ctlT              ctl,
  output logic             respReady
);

  localparam int TO_W = ($clog2(TIMEOUT + 1) > CNT_W) ? $clog2(TIMEOUT + 1) : CNT_W;

  phaseT          stateQ, stateD;
  logic [TO_W-1:0] cntQ, cntD;
  logic            strbDone;

  assign strbDone  = (cntQ >= TO_W'(cfgStrobe)) && !eackN;
  assign respReady = ctl.inDone;

  always_comb begin
    stateD     = stateQ;
    cntD       = cntQ;
    ctl        = '0;
    ctl.inAddr = (stateQ == ST_ADDR);
    ctl.inStrb = (stateQ == ST_STRB);
    ctl.inHold = (stateQ == ST_HOLD);
    ctl.inDone = (stateQ == ST_DONE);
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          cntD        = '0;
          if (!decodeHit) begin
            ctl.setErr = 1'b1;
            stateD     = ST_DONE;
          end else if (!anyActive) begin
            stateD = ST_DONE;
          end else begin
            ctl.loadFirst = 1'b1;
            stateD        = ST_ADDR;
          end
        end
      end
      ST_ADDR: begin
        if (cntQ == TO_W'(cfgSetup)) begin
          cntD   = '0;
          stateD = ST_STRB;
        end else begin
          cntD = cntQ + TO_W'(1);
        end
      end
      ST_STRB: begin
        if (strbDone) begin
          ctl.capture = 1'b1;
          cntD        = '0;
          if (cfgHold != '0) begin
            stateD = ST_HOLD;
          end else if (nextValid) begin
            ctl.stepNext = 1'b1;
            stateD       = ST_ADDR;
          end else begin
            stateD = ST_DONE;
          end
        end else if (cntQ == TO_W'(TIMEOUT - 1)) begin
          ctl.setErr = 1'b1;
          stateD     = ST_DONE;
        end else begin
          cntD = cntQ + TO_W'(1);
        end
      end
      ST_HOLD: begin
        if (cntQ + TO_W'(1) == TO_W'(cfgHold)) begin
          cntD = '0;
          if (nextValid) begin
            ctl.stepNext = 1'b1;
            stateD       = ST_ADDR;
          end else begin
            stateD = ST_DONE;
          end
        end else begin
          cntD = cntQ + TO_W'(1);
        end
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

endmodule

// File: rtl/xbusDatapath.sv
module xbusDatapath
  import xbusPkg::*;
#(
  parameter int NUM_CS  = 6,
  parameter int MATCH_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqWrite,
  input  logic [31:2]               reqAddr,
  input  logic [31:0]               reqWdata,
  input  logic [3:0]                reqBe,
  input  logic                      cfgDemux,
  input  logic [NUM_CS-1:0]         cfgCsEnable,
  input  logic [NUM_CS*MATCH_W-1:0] cfgCsMatch,
  input  ctlT                       ctl,
  output logic                      decodeHit,
  output logic                      anyActive,
  output logic                      nextValid,
  output logic [31:0]               respRdata,
  output logic                      respError,
  output logic [NUM_CS-1:0]         csN,
  output logic                      ale,
  output logic                      rdN,
  output logic                      wrN,
  output logic [3:0]                beN,
  output logic [31:0]               adOut,
  output logic                      adOe,
  input  logic [31:0]               adIn,
  output logic [23:0]               addrOut
);

  // request state
  logic [31:2]       addrQ;
  logic [31:0]       wdataQ;
  logic [31:0]       rdataQ;
  logic [3:0]        beQ;
  logic              writeQ;
  widthT             widthQ;
  logic [NUM_CS-1:0] csQ;
  logic [1:0]        subQ;
  logic              errQ;

  // decode of the incoming request
  logic              winOk;
  logic [NUM_CS-1:0] hitVec;
  logic [NUM_CS-1:0] csPick;
  widthT             reqWidth;
  logic [3:0]        loadMask, curMask;
  logic [1:0]        firstIdx, nextIdx;

  function automatic logic [3:0] laneMask(widthT w, logic [3:0] be);
    case (w)
      W8:      return be;
      W16:     return {2'b00, |be[3:2], |be[1:0]};
      default: return {3'b000, |be};
    endcase
  endfunction

  assign winOk = (reqAddr[31:28] == 4'h1) && (reqAddr[27:26] != 2'b11);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csHit
    assign hitVec[i] = cfgCsEnable[i] && winOk &&
                       (cfgCsMatch[i*MATCH_W +: MATCH_W] == reqAddr[27:24]);
  end

  assign csPick    = hitVec & (~hitVec + NUM_CS'(1));
  assign decodeHit = |hitVec;

  always_comb begin
    reqWidth = widthT'(reqAddr[27:26]);
    if (cfgDemux && reqWidth == W32) reqWidth = W16;
  end

  assign loadMask  = laneMask(reqWidth, reqBe);
  assign curMask   = laneMask(widthQ, beQ);
  assign anyActive = |loadMask;

  always_comb begin
    firstIdx = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (loadMask[i]) firstIdx = 2'(i);
    end
  end

  always_comb begin
    nextValid = 1'b0;
    nextIdx   = subQ;
    for (int i = 3; i >= 0; i--) begin
      if (curMask[i] && i > int'(subQ)) begin
        nextValid = 1'b1;
        nextIdx   = 2'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      beQ    <= '0;
      writeQ <= 1'b0;
      widthQ <= W32;
      csQ    <= '0;
      subQ   <= '0;
      errQ   <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqBe;
        writeQ <= reqWrite;
        widthQ <= reqWidth;
        csQ    <= csPick;
        rdataQ <= '0;
        errQ   <= 1'b0;
      end
      if (ctl.loadFirst) subQ <= firstIdx;
      if (ctl.stepNext)  subQ <= nextIdx;
      if (ctl.capture && !writeQ) begin
        case (widthQ)
          W8:      rdataQ[{subQ, 3'b000} +: 8]   <= adIn[7:0];
          W16:     rdataQ[{subQ[0], 4'b0000} +: 16] <= adIn[15:0];
          default: rdataQ <= adIn;
        endcase
      end
      if (ctl.setErr) errQ <= 1'b1;
    end
  end

  // per sub-cycle address, data and lane enables
  logic [31:0] extAddr;
  logic [31:0] laneData;
  logic [3:0]  laneBe;
  logic        active;

  always_comb begin
    case (widthQ)
      W8: begin
        extAddr  = {addrQ, subQ};
        laneData = {24'h0, wdataQ[{subQ, 3'b000} +: 8]};
        laneBe   = 4'b0001;
      end
      W16: begin
        extAddr  = {addrQ, subQ[0], 1'b0};
        laneData = {16'h0, wdataQ[{subQ[0], 4'b0000} +: 16]};
        laneBe   = {2'b00, beQ[{subQ[0], 1'b0} +: 2]};
      end
      default: begin
        extAddr  = {addrQ, 2'b00};
        laneData = wdataQ;
        laneBe   = beQ;
      end
    endcase
  end

  assign active    = ctl.inAddr | ctl.inStrb | ctl.inHold;
  assign csN       = active ? ~csQ : '1;
  assign ale       = ctl.inAddr & ~cfgDemux;
  assign rdN       = ~(ctl.inStrb & ~writeQ);
  assign wrN       = ~(ctl.inStrb & writeQ);
  assign beN       = active ? ~laneBe : 4'hF;
  assign adOut     = (ctl.inAddr && !cfgDemux) ? extAddr :
                     ((active && writeQ) ? laneData : 32'h0);
  assign adOe      = (ctl.inAddr && !cfgDemux) || (active && writeQ);
  assign addrOut   = active ? extAddr[23:0] : 24'h0;
  assign respRdata = rdataQ;
  assign respError = errQ;

endmodule

// File: rtl/xbusBridge.sv
module xbusBridge
  import xbusPkg::*;
#(
  parameter int NUM_CS  = 6,
  parameter int CNT_W   = 4,
  parameter int TIMEOUT = 255
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [31:2]          reqAddr,
  input  logic [31:0]          reqWdata,
  input  logic [3:0]           reqBe,
  output logic                 respReady,
  output logic [31:0]          respRdata,
  output logic                 respError,
  input  logic                 cfgDemux,
  input  logic [CNT_W-1:0]     cfgSetup,
  input  logic [CNT_W-1:0]     cfgStrobe,
  input  logic [CNT_W-1:0]     cfgHold,
  input  logic [NUM_CS-1:0]    cfgCsEnable,
  input  logic [NUM_CS*4-1:0]  cfgCsMatch,
  output logic [NUM_CS-1:0]    csN,
  output logic                 ale,
  output logic                 rdN,
  output logic                 wrN,
  output logic [3:0]           beN,
  output logic [31:0]          adOut,
  output logic                 adOe,
  input  logic [31:0]          adIn,
  output logic [23:0]          addrOut,
  input  logic                 eackN
);

  ctlT  ctl;
  logic decodeHit, anyActive, nextValid;

  xbusCtrl #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .decodeHit(decodeHit), .anyActive(anyActive), .nextValid(nextValid),
    .eackN(eackN), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe), .cfgHold(cfgHold),
    .ctl(ctl), .respReady(respReady)
  );

  xbusDatapath #(.NUM_CS(NUM_CS), .MATCH_W(4)) i_dp (
    .clk(clk), .rstN(rstN), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .cfgDemux(cfgDemux),
    .cfgCsEnable(cfgCsEnable), .cfgCsMatch(cfgCsMatch), .ctl(ctl),
    .decodeHit(decodeHit), .anyActive(anyActive), .nextValid(nextValid),
    .respRdata(respRdata), .respError(respError), .csN(csN), .ale(ale),
    .rdN(rdN), .wrN(wrN), .beN(beN), .adOut(adOut), .adOe(adOe),
    .adIn(adIn), .addrOut(addrOut)
  );

endmodule

// File: rtl/xbusChecker.sv
module xbusChecker #(
  parameter int NUM_CS  = 6,
  parameter int TIMEOUT = 255
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgDemux,
  input logic [NUM_CS-1:0] csN,
  input logic              ale,
  input logic              rdN,
  input logic              wrN,
  input logic              respReady
);

  logic [15:0] lowRun;
  logic        strbLow;

  assign strbLow = !rdN || !wrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowRun <= '0;
    else if (strbLow) lowRun <= lowRun + 16'd1;
    else lowRun <= '0;
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R3
  AST_STROBE_HAS_CS: assert property (@(posedge clk) disable iff (!rstN)
    strbLow |-> (csN != '1)); // R3
  AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (strbLow && $past(strbLow)) |-> $stable(csN)); // R3
  AST_ALE_NOT_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN)); // R4
  AST_DEMUX_NO_ALE: assert property (@(posedge clk) disable iff (!rstN)
    cfgDemux |-> !ale); // R5
  AST_ACK_TIMEOUT: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= 16'(TIMEOUT)); // R12
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R13
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respReady |=> !respReady); // R13

endmodule

bind xbusBridge xbusChecker #(.NUM_CS(NUM_CS), .TIMEOUT(TIMEOUT)) i_chk (
  .clk(clk), .rstN(rstN), .cfgDemux(cfgDemux), .csN(csN), .ale(ale),
  .rdN(rdN), .wrN(wrN), .respReady(respReady)
);

// File: tb/test_xbusBridge.sv
`timescale 1ns/1ps
module test_xbusBridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:2] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        respReady, respError;
  logic [31:0] respRdata;
  logic        cfgDemux = 1'b0;
  logic [3:0]  cfgSetup = '0, cfgStrobe = '0, cfgHold = '0;
  logic [5:0]  cfgCsEnable = 6'b101111;
  logic [23:0] cfgCsMatch;
  logic [5:0]  csN;
  logic        ale, rdN, wrN, adOe;
  logic [3:0]  beN;
  logic [31:0] adOut, adIn;
  logic [23:0] addrOut;
  logic        eackN = 1'b1;

  int total = 0;
  int bad = 0;

  // CS0 {win0,0} CS1 {win1,0} CS2 {win2,0} CS3 {win2,1} CS4 {win0,1} CS5 {win1,3}
  logic [3:0] cs4Match = 4'b0001;
  assign cfgCsMatch = {4'b0111, cs4Match, 4'b1001, 4'b1000, 4'b0100, 4'b0000};

  always #5 clk = ~clk;

  xbusBridge i_xbusBridge (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .respReady(respReady), .respRdata(respRdata), .respError(respError),
    .cfgDemux(cfgDemux), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .cfgHold(cfgHold), .cfgCsEnable(cfgCsEnable), .cfgCsMatch(cfgCsMatch),
    .csN(csN), .ale(ale), .rdN(rdN), .wrN(wrN), .beN(beN), .adOut(adOut),
    .adOe(adOe), .adIn(adIn), .addrOut(addrOut), .eackN(eackN)
  );

  // external device model: byte memory, all windows alias address bits [7:0]
  logic [7:0]  mem [256];
  logic [31:0] latFull = '0;
  logic [31:0] curFull;
  logic [7:0]  curA;
  int          strbCnt = 0, aleCnt = 0, lowCnt = 0, ackWait = 0;
  logic        noAck = 1'b0, prevLow = 1'b0;
  logic [5:0]  csSeen = '1;
  logic [31:0] addrLog [4];
  logic [3:0]  beLog [4];

  assign curFull = cfgDemux ? {8'h0, addrOut} : latFull;
  assign curA    = curFull[7:0];

  always_comb adIn = {mem[curA + 8'd3], mem[curA + 8'd2], mem[curA + 8'd1], mem[curA]};

  always @(negedge clk) begin
    logic strobeLow;
    if (ale) begin
      latFull = adOut;
      aleCnt++;
    end
    strobeLow = !rdN || !wrN;
    if (strobeLow) begin
      if (!prevLow) begin
        if (strbCnt < 4) begin
          addrLog[strbCnt] = curFull;
          beLog[strbCnt]   = beN;
        end
        csSeen = csN;
        strbCnt++;
      end
      lowCnt++;
      if (!wrN) begin
        for (int i = 0; i < 4; i++)
          if (!beN[i]) mem[curA + 8'(i)] = adOut[8*i +: 8];
      end
      eackN = noAck ? 1'b1 : !(lowCnt > ackWait);
    end else begin
      lowCnt = 0;
      eackN  = 1'b1;
    end
    prevLow = strobeLow;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic dm, input logic wr, input logic [31:0] addr,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic [3:0] s, input logic [3:0] w, input logic [3:0] h,
                        output int lat, output logic [31:0] rd, output logic er);
    cfgDemux  = dm;
    cfgSetup  = s;
    cfgStrobe = w;
    cfgHold   = h;
    strbCnt   = 0;
    aleCnt    = 0;
    csSeen    = '1;
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqAddr   = addr[31:2];
    reqBe     = be;
    reqWdata  = wd;
    lat       = 0;
    while (lat < 2000) begin
      @(posedge clk);
      #1;
      lat++;
      if (respReady) break;
    end
    if (!respReady) chk(1'b0, "watchdog no response", 32'(lat), 32'd0);
    rd = respRdata;
    er = respError;
    chk(csN == 6'h3F, "R3 idle chip selects in response cycle", 32'(csN), 32'h3F);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  typedef struct packed {
    logic        dm;
    logic        wr;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [2:0]  nstrb;
    logic [3:0]  s;
    logic [3:0]  w;
    logic [3:0]  h;
    logic [5:0]  cs;
  } vecT;

  localparam int NVEC = 14;
  localparam vecT VECS [NVEC] = '{
    '{1'b0, 1'b1, 32'h1000_0010, 4'hF, 32'h1122_3344, 3'd1, 4'd1, 4'd1, 4'd1, 6'b111110},
    '{1'b0, 1'b0, 32'h1000_0010, 4'hF, 32'h1122_3344, 3'd1, 4'd0, 4'd0, 4'd0, 6'b111110},
    '{1'b0, 1'b1, 32'h1800_0020, 4'hF, 32'hA1B2_C3D4, 3'd4, 4'd0, 4'd2, 4'd0, 6'b111011},
    '{1'b0, 1'b0, 32'h1000_0020, 4'hF, 32'hA1B2_C3D4, 3'd1, 4'd2, 4'd0, 4'd1, 6'b111110},
    '{1'b0, 1'b0, 32'h1800_0020, 4'hF, 32'hA1B2_C3D4, 3'd4, 4'd1, 4'd0, 4'd0, 6'b111011},
    '{1'b0, 1'b1, 32'h1400_0030, 4'hC, 32'h5566_7788, 3'd1, 4'd2, 4'd0, 4'd1, 6'b111101},
    '{1'b0, 1'b0, 32'h1000_0030, 4'hF, 32'h5566_0000, 3'd1, 4'd0, 4'd1, 4'd0, 6'b111110},
    '{1'b0, 1'b0, 32'h1400_0030, 4'hC, 32'h5566_0000, 3'd1, 4'd0, 4'd0, 4'd2, 6'b111101},
    '{1'b0, 1'b0, 32'h1900_0030, 4'hA, 32'h5500_0000, 3'd2, 4'd1, 4'd1, 4'd0, 6'b110111},
    '{1'b1, 1'b1, 32'h1000_0040, 4'hF, 32'hCAFE_F00D, 3'd2, 4'd1, 4'd1, 4'd0, 6'b111110},
    '{1'b1, 1'b0, 32'h1800_0040, 4'hF, 32'hCAFE_F00D, 3'd4, 4'd0, 4'd0, 4'd1, 6'b111011},
    '{1'b1, 1'b0, 32'h1400_0040, 4'hF, 32'hCAFE_F00D, 3'd2, 4'd3, 4'd1, 4'd0, 6'b111101},
    '{1'b0, 1'b1, 32'h1000_0050, 4'h5, 32'h1234_5678, 3'd1, 4'd0, 4'd0, 4'd0, 6'b111110},
    '{1'b0, 1'b0, 32'h1000_0050, 4'hF, 32'h0034_0078, 3'd1, 4'd1, 4'd0, 4'd0, 6'b111110}
  };

  initial begin
    #1_500_000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] rd;
    logic er;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // reset state (R3, R13)
    chk(csN == 6'h3F, "R3 reset chip selects", 32'(csN), 32'h3F);
    chk(rdN && wrN && !ale, "R13 reset strobes", {29'h0, rdN, wrN, ale}, 32'h6);
    chk(!respReady, "R13 reset ready", 32'(respReady), 32'h0);
    rstN = 1'b1;
    @(posedge clk);
    #1;

    // table walk: R1 R4 R5 R6 R8 R9 R11
    for (int k = 0; k < NVEC; k++) begin
      vecT v;
      int expLat;
      v = VECS[k];
      access(v.dm, v.wr, v.addr, v.be, v.data, v.s, v.w, v.h, lat, rd, er);
      expLat = 1 + int'(v.nstrb) * (int'(v.s) + 1 + int'(v.w) + 1 + int'(v.h));
      chk(lat == expLat, "R6 response latency", 32'(lat), 32'(expLat));
      chk(!er, "R2 no error on hit", 32'(er), 32'h0);
      chk(strbCnt == int'(v.nstrb), "R1 external cycle count", 32'(strbCnt), 32'(v.nstrb));
      chk(csSeen == v.cs, "R2 chip select chosen", 32'(csSeen), 32'(v.cs));
      if (!v.wr) chk(rd == v.data, "R11 gathered read data", rd, v.data);
      if (v.dm) chk(aleCnt == 0, "R5 no latch enable in demux", 32'(aleCnt), 32'h0);
      else chk(aleCnt == int'(v.nstrb) * (int'(v.s) + 1), "R4 address phase length",
               32'(aleCnt), 32'(int'(v.nstrb) * (int'(v.s) + 1)));
    end

    // R2 address outside all windows
    access(1'b0, 1'b1, 32'h1C00_0000, 4'hF, 32'h0, 4'd1, 4'd1, 4'd1, lat, rd, er);
    chk(er && lat == 1, "R2 window miss error", {31'h0, er}, 32'h1);
    chk(strbCnt == 0, "R2 window miss no cycle", 32'(strbCnt), 32'h0);
    // R2 disabled chip select
    access(1'b0, 1'b0, 32'h1100_0000, 4'hF, 32'h0, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(er && strbCnt == 0, "R2 disabled select error", {31'h0, er}, 32'h1);
    // R2 lowest index wins when CS4 also matches
    cs4Match    = 4'b0000;
    cfgCsEnable = 6'b111111;
    access(1'b0, 1'b0, 32'h1000_0010, 4'hF, 32'h0, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(csSeen == 6'b111110, "R2 lowest index priority", 32'(csSeen), 32'h3E);
    cs4Match    = 4'b0001;
    cfgCsEnable = 6'b101111;
    // R10 no enabled bytes
    access(1'b0, 1'b1, 32'h1000_0010, 4'h0, 32'hFFFF_FFFF, 4'd1, 4'd1, 4'd1, lat, rd, er);
    chk(lat == 1 && !er && strbCnt == 0, "R10 empty access", 32'(lat), 32'h1);
    access(1'b0, 1'b0, 32'h1000_0010, 4'hF, 32'h0, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(rd == 32'h1122_3344, "R10 memory untouched", rd, 32'h1122_3344);

    // R8 byte order and skipping
    access(1'b0, 1'b1, 32'h1800_0060, 4'h9, 32'hDD00_00AA, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(strbCnt == 2, "R8 skipped bytes", 32'(strbCnt), 32'h2);
    chk(addrLog[0] == 32'h1800_0060, "R8 first byte address", addrLog[0], 32'h1800_0060);
    chk(addrLog[1] == 32'h1800_0063, "R8 last byte address", addrLog[1], 32'h1800_0063);
    chk(beLog[0] == 4'b1110 && beLog[1] == 4'b1110, "R8 byte lane enable", 32'(beLog[1]), 32'hE);
    access(1'b0, 1'b0, 32'h1000_0060, 4'hF, 32'h0, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(rd == 32'hDD00_00AA, "R8 scattered bytes stored", rd, 32'hDD00_00AA);

    // R9 halfword order
    access(1'b0, 1'b1, 32'h1400_0070, 4'hF, 32'h0102_0304, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(addrLog[0] == 32'h1400_0070, "R9 lower half address", addrLog[0], 32'h1400_0070);
    chk(addrLog[1] == 32'h1400_0072, "R9 upper half address", addrLog[1], 32'h1400_0072);
    chk(beLog[0] == 4'b1100, "R9 half lane enables", 32'(beLog[0]), 32'hC);
    access(1'b0, 1'b0, 32'h1000_0070, 4'hF, 32'h0, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(rd == 32'h0102_0304, "R9 halves stored", rd, 32'h0102_0304);

    // R7 acknowledge extends the strobe
    ackWait = 6;
    access(1'b0, 1'b0, 32'h1000_0010, 4'hF, 32'h0, 4'd0, 4'd1, 4'd0, lat, rd, er);
    chk(lat == 9, "R7 acknowledge extension latency", 32'(lat), 32'd9);
    chk(rd == 32'h1122_3344 && !er, "R7 data after late ack", rd, 32'h1122_3344);
    ackWait = 0;

    // R12 acknowledge never arrives
    noAck = 1'b1;
    access(1'b0, 1'b0, 32'h1800_0010, 4'hF, 32'h0, 4'd0, 4'd0, 4'd2, lat, rd, er);
    chk(er, "R12 timeout error", {31'h0, er}, 32'h1);
    chk(lat == 257, "R12 timeout latency", 32'(lat), 32'd257);
    chk(strbCnt == 1, "R12 remaining cycles dropped", 32'(strbCnt), 32'h1);
    noAck = 1'b0;
    access(1'b0, 1'b0, 32'h1000_0010, 4'hF, 32'h0, 4'd0, 4'd0, 4'd0, lat, rd, er);
    chk(!er && rd == 32'h1122_3344, "R12 recovery after timeout", rd, 32'h1122_3344);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule